// File: doc/BRIEF.md
# Offset QPSK Symbol Aligner

This block sits in a carrier-removal datapath and undoes the half-symbol stagger of offset (staggered) QPSK. Each accepted input beat carries one in-phase and one quadrature sample. With offset alignment on, the in-phase sample from the previous beat is paired with the quadrature sample of the current beat. The I and Q rails then line up on the same symbol.

A second stage can decimate the stream by two. With holding on, the block keeps one aligned pair out of every two beats and presents it on two successive output beats. A strobe marks the first of the two. An external sync pulse, sampled with an accepted beat, forces that beat to be a kept one. This places the kept pairs on the symbol boundary.

Both streams use valid/ready. An input beat transfers when `in_valid` and `in_ready` are both high. An output beat transfers when `out_valid` and `out_ready` are both high. Each accepted input beat yields exactly one output beat, one cycle later, from a single output register. While an output beat waits for `out_ready`, the block drops `in_ready` and holds the output steady. The rails are 12-bit two's complement by default.

Top module: `oqpsk_aligner`

## Requirements
- R1: With `offset_en` low, an output beat carries the I and Q samples of one single accepted input beat. It appears one cycle after that beat is accepted.
- R2: With `offset_en` high, the output I is the I sample of the previously accepted beat, and the output Q is the Q sample of the current beat.
- R3: With `hold_en` low, every accepted beat produces a new aligned pair with `out_first` = 1.
- R4: With `hold_en` high, accepted beats alternate between two kinds. A kept beat outputs its new aligned pair with `out_first` = 1. The next beat repeats that pair with `out_first` = 0 and discards its own aligned pair.
- R5: An accepted beat with `sync` high is always a kept beat (`out_first` = 1). The beat after it is a repeat beat when `hold_en` is high.
- R6: During and right after reset, `out_valid` is 0 and `in_ready` is 1. The I delay register holds 0, so the first offset-mode output carries I = 0. The first beat is a kept beat.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_i`, `out_q`, `out_first` and `out_valid` stay unchanged.
- R8: A cycle without an accepted beat does not advance the delay register or the hold phase. If the pending output is taken in that cycle, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| offset_en | input | 1 | Pair the previous I with the current Q |
| hold_en | input | 1 | Decimate by two, repeating each kept pair |
| sync | input | 1 | Force the accepted beat to be a kept beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_i | output | 12 | Aligned in-phase sample |
| out_q | output | 12 | Aligned quadrature sample |
| out_first | output | 1 | Strobe: new kept pair (first of the held two) |

## Verification
Every output result falls due exactly one clock after the input beat that causes it is accepted. The bench drives each beat on a falling edge, lets one rising edge register it, and compares the outputs on the next falling edge. The expected values for the I delay and the hold phase are worked out by hand, beat by beat from reset. During a stall the bench holds `out_ready` low across a rising edge and then checks that nothing moved. Idle cycles are checked one clock after the last accepted beat, which shows the hold phase did not advance.

// File: rtl/oqpsk_pkg.sv
package oqpsk_pkg;
  // Decimation phase of the next accepted beat.
  typedef enum logic {
    PH_KEEP   = 1'b0,
    PH_REPEAT = 1'b1
  } hold_phase_e;

  function automatic hold_phase_e next_phase(input hold_phase_e cur);
    return (cur == PH_KEEP) ? PH_REPEAT : PH_KEEP;
  endfunction
endpackage

// File: rtl/oqpsk_skew.sv
// One-beat delay on the in-phase rail, selected by offset_en.
module oqpsk_skew #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                offset_en,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic [SAMPLE_W-1:0] al_i,
  output logic [SAMPLE_W-1:0] al_q
);
  logic [SAMPLE_W-1:0] i_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_prev <= '0;
    end else if (take) begin
      i_prev <= in_i;
    end
  end

  always_comb begin
    al_i = offset_en ? i_prev : in_i;
    al_q = in_q;
  end
endmodule

// File: rtl/oqpsk_decim.sv
// Keep/repeat sequencer: every other beat reuses the last kept pair.
module oqpsk_decim
  import oqpsk_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                hold_en,
  input  logic                sync,
  input  logic [SAMPLE_W-1:0] al_i,
  input  logic [SAMPLE_W-1:0] al_q,
  output logic [SAMPLE_W-1:0] sel_i,
  output logic [SAMPLE_W-1:0] sel_q,
  output logic                keep
);
  hold_phase_e         phase_q;
  hold_phase_e         phase_now;
  logic [SAMPLE_W-1:0] kept_i;
  logic [SAMPLE_W-1:0] kept_q;

  always_comb begin
    phase_now = sync ? PH_KEEP : phase_q;
    keep      = !hold_en || (phase_now == PH_KEEP);
    sel_i     = keep ? al_i : kept_i;
    sel_q     = keep ? al_q : kept_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_KEEP;
    end else if (take) begin
      phase_q <= next_phase(phase_now);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_i <= '0;
      kept_q <= '0;
    end else if (take && keep) begin
      kept_i <= al_i;
      kept_q <= al_q;
    end
  end
endmodule

// File: rtl/oqpsk_outstage.sv
// Single output register with valid/ready handshake.
module oqpsk_outstage #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                out_ready,
  input  logic [SAMPLE_W-1:0] d_i,
  input  logic [SAMPLE_W-1:0] d_q,
  input  logic                d_first,
  output logic                in_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                out_first
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i     <= '0;
      out_q     <= '0;
      out_first <= 1'b0;
    end else if (take) begin
      out_i     <= d_i;
      out_q     <= d_q;
      out_first <= d_first;
    end
  end
endmodule

// File: rtl/oqpsk_aligner.sv
module oqpsk_aligner #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                offset_en,
  input  logic                hold_en,
  input  logic                sync,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                out_first
);
  logic                take;
  logic [SAMPLE_W-1:0] al_i, al_q;
  logic [SAMPLE_W-1:0] sel_i, sel_q;
  logic                keep;

  assign take = in_valid && in_ready;

  oqpsk_skew #(.SAMPLE_W(SAMPLE_W)) u_skew (
    .clk(clk), .rst_n(rst_n), .take(take), .offset_en(offset_en),
    .in_i(in_i), .in_q(in_q), .al_i(al_i), .al_q(al_q)
  );

  oqpsk_decim #(.SAMPLE_W(SAMPLE_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .take(take), .hold_en(hold_en), .sync(sync),
    .al_i(al_i), .al_q(al_q), .sel_i(sel_i), .sel_q(sel_q), .keep(keep)
  );

  oqpsk_outstage #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .out_ready(out_ready),
    .d_i(sel_i), .d_q(sel_q), .d_first(keep),
    .in_ready(in_ready), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .out_first(out_first)
  );
endmodule

// File: rtl/oqpsk_aligner_chk.sv
module oqpsk_aligner_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SAMPLE_W-1:0] in_i,
  input logic [SAMPLE_W-1:0] in_q,
  input logic                offset_en,
  input logic                hold_en,
  input logic                sync,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_i,
  input logic [SAMPLE_W-1:0] out_q,
  input logic                out_first
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_same_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !offset_en && (!hold_en || sync)) |=>
      (out_valid && out_i == $past(in_i) && out_q == $past(in_q)));

  assert_q_current_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && offset_en && (!hold_en || sync)) |=> (out_q == $past(in_q)));

  assert_no_hold_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hold_en) |=> out_first);

  assert_repeat_needs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !out_first && out_valid) |=> (out_first || $past(hold_en)));

  assert_sync_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sync) |=> out_first);

  assert_reset_idle_R6: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_first)));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && out_ready) |=> !out_valid);
endmodule

bind oqpsk_aligner oqpsk_aligner_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_i(in_i), .in_q(in_q), .offset_en(offset_en), .hold_en(hold_en),
  .sync(sync), .out_valid(out_valid), .out_ready(out_ready),
  .out_i(out_i), .out_q(out_q), .out_first(out_first)
);

// File: tb/oqpsk_aligner_test.sv
module oqpsk_aligner_test;
  localparam int W = 12;
  localparam int NV = 14;
  // fields: in_i, in_q, offset_en, hold_en, sync, exp_i, exp_q, exp_first
  localparam int VEC [NV][8] = '{
    '{   10,   20, 0, 0, 0,    10,   20, 1},
    '{   11,   21, 0, 0, 0,    11,   21, 1},
    '{   -5,   22, 1, 0, 0,    11,   22, 1},
    '{    7,   -8, 1, 0, 0,    -5,   -8, 1},
    '{  100,  200, 1, 1, 1,     7,  200, 1},
    '{  101,  201, 1, 1, 0,     7,  200, 0},
    '{  102,  202, 1, 1, 0,   101,  202, 1},
    '{  103,  203, 1, 1, 1,   102,  203, 1},
    '{  104,  204, 1, 1, 0,   102,  203, 0},
    '{-2048, 2047, 0, 1, 0, -2048, 2047, 1},
    '{ 2047,-2048, 0, 1, 0, -2048, 2047, 0},
    '{    1,    2, 0, 1, 1,     1,    2, 1},
    '{    3,    4, 1, 1, 1,     1,    4, 1},
    '{    5,    6, 1, 0, 0,     3,    6, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_i = '0, in_q = '0;
  logic offset_en = 1'b0, hold_en = 1'b0, sync = 1'b0;
  logic out_valid, out_ready = 1'b1, out_first;
  logic [W-1:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oqpsk_aligner #(.SAMPLE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .offset_en(offset_en), .hold_en(hold_en),
    .sync(sync), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .out_first(out_first)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int ei, input int eq, input int ef);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " i"}, int'($signed(out_i)), ei);
    chk({req, " q"}, int'($signed(out_q)), eq);
    chk({req, " first"}, int'(out_first), ef);
  endtask

  task automatic drive(input int i, input int q, input bit off, input bit hld, input bit sy);
    in_valid  = 1'b1;
    in_i      = W'(i);
    in_q      = W'(q);
    offset_en = off;
    hold_en   = hld;
    sync      = sy;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 out_valid in reset", int'(out_valid), 0);
    chk("R6 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;

    // Table walk: R1..R5 (one beat per clock, output due next clock)
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][0], VEC[k][1], VEC[k][2][0], VEC[k][3][0], VEC[k][4][0]);
      @(negedge clk);
      chk_out($sformatf("R1-5 vec%0d", k), VEC[k][5], VEC[k][6], VEC[k][7]);
    end

    // R6: delay register cleared, first beat kept
    do_reset();
    chk("R6 out_valid after reset", int'(out_valid), 0);
    drive(9, 9, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R6 first offset beat", 0, 9, 1);

    // R8: idle cycle drains output and does not advance phase
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 out_valid drops", int'(out_valid), 0);
    drive(30, 31, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R8 phase held over idle", 0, 9, 0);

    // R7: back-pressure
    do_reset();
    drive(40, 41, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R7 before stall", 40, 41, 1);
    out_ready = 1'b0;
    drive(50, 51, 1'b0, 1'b1, 1'b0);
    #0;
    chk("R7 in_ready low on stall", int'(in_ready), 0);
    @(negedge clk);
    chk_out("R7 held during stall", 40, 41, 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk_out("R7 beat after stall repeats", 40, 41, 0);
    drive(60, 61, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R7 next kept beat", 60, 61, 1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule